// File: doc/BRIEF.md
# Sparse Directory Cache

This block keeps coherence directory state for only the memory blocks that are currently cached somewhere. Directory state is not kept for every block in memory. Storage is a set-associative array of entries. Each entry holds a block tag, a per-node sharer bit vector and a dirty flag. A protocol engine sends two kinds of request on one port. A lookup reads the recorded state of a block address. An update writes new sharer and dirty state for a block, and allocates an entry when the block is not present.

Nothing stands behind this array. When an update misses in a full set, an occupied way has to be reclaimed. The directory cannot write that entry back anywhere, so it sends an invalidation to every node the victim lists. These go out on an output stream, one node per cycle. The request port stays stalled until the stream is done. Only then is the new entry installed. An update that leaves a block with no sharers and not dirty releases its entry.

The default configuration has 16 sets of 4 ways, 8 nodes and 10-bit block addresses. Address bits [3:0] select the set, and the bits above them form the tag. Victims come from a per-set binary-tree pseudo-LRU. An invalid way is always used first.

Top module: `sdir_cache`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1 and `inv_valid` is 0. A lookup that misses returns `rsp_hit`=0 with an all-zero sharer vector and `rsp_dirty`=0.
- R2: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. `req_op` is 0 for a lookup and 1 for an update. An accepted lookup raises `rsp_valid` for exactly the next cycle, carrying the hit flag, sharer vector and dirty flag.
- R3: An update that hits replaces that entry's sharer vector and dirty flag with the request's values.
- R4: An update that misses, with a nonzero sharer vector or dirty set, goes into the lowest-numbered invalid way of its set when one exists. It causes no stall and no invalidation.
- R5: An update that hits with an all-zero sharer vector and dirty clear frees the entry. Later lookups miss, and the freed way is reused before any valid way is evicted.
- R6: An update that misses with an all-zero sharer vector and dirty clear allocates nothing. A later lookup of that address still misses.
- R7: In a full set the victim is chosen by a 3-bit tree per set, which starts at zero. Bit 0 picks ways 0–1 (when 0) or ways 2–3 (when 1). Bit 1 picks way 0 (0) or way 1 (1), and bit 2 picks way 2 (0) or way 3 (1). A hit, or the install of an entry, sets the bits on its path to point away from the way that was touched. A lookup miss leaves the bits unchanged.
- R8: An evicting update emits one invalidation per sharer of the victim, one per cycle, in ascending node order. The first appears in the cycle after acceptance. Each carries `inv_addr` = {victim tag, set index}.
- R9: `req_ready` is 0 in exactly the cycles in which invalidations are emitted. After that the new entry holds exactly the request's state, and the evicted address misses.
- R10: A victim with an empty sharer vector (dirty only) is replaced without any invalidation or stall.
- R11: Addresses with equal tags but different set indices occupy independent entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 1 | 0 lookup, 1 update |
| req_addr | input | 10 | Block address; [3:0] set index, [9:4] tag |
| req_sharers | input | 8 | New sharer vector for an update |
| req_dirty | input | 1 | New dirty flag for an update |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Block had a valid entry |
| rsp_sharers | output | 8 | Recorded sharer vector |
| rsp_dirty | output | 1 | Recorded dirty flag |
| inv_valid | output | 1 | Invalidation present this cycle |
| inv_addr | output | 10 | Block address being invalidated |
| inv_node | output | 3 | Node to invalidate |

## Verification
The bench fills one set and then checks which way each of two evictions reclaims. A wrong tree walk or a missing update on lookup hits would invalidate the wrong block's sharers. It counts the invalidation cycles against the stall window, which catches a design that installs early, drops the last sharer, or emits nodes out of order. It also covers three cases that are easy to get wrong. Freeing an entry must make that way the next allocation; otherwise an eviction would happen that was not needed. An all-zero update that misses must not allocate. A dirty-only victim must not stall, and an off-by-one sequencer stalls there. Same-tag addresses in different sets are checked so that aliasing from a bad index split shows up.

// File: rtl/sdir_pkg.sv
package sdir_pkg;
    localparam int NODES  = 8;
    localparam int SETS   = 16;
    localparam int WAYS   = 4;
    localparam int ADDR_W = 10;

    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int NODE_W = $clog2(NODES);

    typedef enum logic { OP_LOOKUP = 1'b0, OP_UPDATE = 1'b1 } op_e;
    typedef enum logic { S_IDLE = 1'b0, S_EVICT = 1'b1 } st_e;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [NODES-1:0] sharers;
        logic             dirty;
    } entry_t;

    function automatic logic [NODE_W-1:0] lowest_node(input logic [NODES-1:0] v);
        logic [NODE_W-1:0] r;
        r = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (v[i]) r = NODE_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/sdir_plru.sv
module sdir_plru
    import sdir_pkg::*;
#(
    parameter int N_SETS = SETS,
    parameter int N_WAYS = WAYS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(N_SETS)-1:0]  rd_set,
    output logic [$clog2(N_WAYS)-1:0]  victim,
    input  logic                       touch_en,
    input  logic [$clog2(N_SETS)-1:0]  touch_set,
    input  logic [$clog2(N_WAYS)-1:0]  touch_way
);
    localparam int LW = $clog2(N_WAYS);
    localparam int NB = N_WAYS - 1;

    logic [NB-1:0] tree [N_SETS];
    logic [NB-1:0] nxt;

    // walk toward the least recently pointed leaf
    always_comb begin
        int node;
        node = 0;
        for (int lvl = 0; lvl < LW; lvl++) begin
            node = 2 * node + 1 + (tree[rd_set][node] ? 1 : 0);
        end
        victim = LW'(node - NB);
    end

    // point every node on the touched path away from it
    always_comb begin
        int node;
        logic dir;
        nxt  = tree[touch_set];
        node = 0;
        for (int lvl = 0; lvl < LW; lvl++) begin
            dir       = touch_way[LW-1-lvl];
            nxt[node] = ~dir;
            node      = 2 * node + 1 + (dir ? 1 : 0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < N_SETS; s++) tree[s] <= '0;
        end else if (touch_en) begin
            tree[touch_set] <= nxt;
        end
    end
endmodule

// File: rtl/sdir_way_match.sv
module sdir_way_match
    import sdir_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  entry_t [WAYS-1:0]     set_ent,
    input  logic [TAG_W-1:0]      tag,
    input  logic [WAY_W-1:0]      plru_way,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way,
    output logic [WAY_W-1:0]      alloc_way
);
    logic [WAYS-1:0] hit_vec;
    logic [WAYS-1:0] free_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w]  = set_ent[w].valid && (set_ent[w].tag == tag);
        assign free_vec[w] = !set_ent[w].valid;
    end

    always_comb begin
        hit_way   = '0;
        alloc_way = plru_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])  hit_way   = WAY_W'(w);
            if (free_vec[w]) alloc_way = WAY_W'(w);
        end
    end

    assign hit = |hit_vec;

    // R3: an address may live in at most one way
    a_r3_unique_hit: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
endmodule

// File: rtl/sdir_inv_seq.sv
module sdir_inv_seq
    import sdir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [NODES-1:0]  load_vec,
    output logic              inv_valid,
    output logic [NODE_W-1:0] inv_node,
    output logic              last
);
    logic [NODES-1:0] pend;

    assign inv_valid = |pend;
    assign inv_node  = lowest_node(pend);
    assign last      = inv_valid && ((pend & (pend - 1'b1)) == '0);

    always_ff @(posedge clk) begin
        if (rst)            pend <= '0;
        else if (load)      pend <= load_vec;
        else if (inv_valid) pend <= pend & (pend - 1'b1);
    end

    // R8: nodes leave in strictly ascending order within one eviction
    a_r8_ascending: assert property (@(posedge clk) disable iff (rst)
        inv_valid && $past(inv_valid) && !$past(last) |-> inv_node > $past(inv_node));
endmodule

// File: rtl/sdir_cache.sv
module sdir_cache
    import sdir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NODES-1:0]  req_sharers,
    input  logic              req_dirty,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [NODES-1:0]  rsp_sharers,
    output logic              rsp_dirty,
    output logic              inv_valid,
    output logic [ADDR_W-1:0] inv_addr,
    output logic [NODE_W-1:0] inv_node
);
    entry_t mem [SETS][WAYS];
    entry_t [WAYS-1:0] set_ent;
    st_e state;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             hit, accept, is_upd, nonempty, need_evict, direct_wr, seq_last;
    logic [WAY_W-1:0] hit_way, alloc_way, plru_way, wr_way, touch_way;
    logic             touch_en;
    logic [IDX_W-1:0] touch_set;
    entry_t           victim;

    logic [IDX_W-1:0] h_idx;
    logic [TAG_W-1:0] h_tag, h_vtag;
    logic [WAY_W-1:0] h_way;
    logic [NODES-1:0] h_sh;
    logic             h_dirty;

    assign idx = req_addr[IDX_W-1:0];
    assign tag = req_addr[ADDR_W-1:IDX_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) set_ent[w] = mem[idx][w];
    end

    sdir_way_match u_match (
        .clk(clk), .rst(rst), .set_ent(set_ent), .tag(tag), .plru_way(plru_way),
        .hit(hit), .hit_way(hit_way), .alloc_way(alloc_way)
    );

    assign req_ready  = (state == S_IDLE);
    assign accept     = req_valid && req_ready;
    assign is_upd     = (req_op == OP_UPDATE);
    assign nonempty   = (req_sharers != '0) || req_dirty;
    assign victim     = set_ent[alloc_way];
    assign need_evict = accept && is_upd && !hit && nonempty &&
                        victim.valid && (victim.sharers != '0);
    assign direct_wr  = accept && is_upd && (hit || (nonempty && !need_evict));
    assign wr_way     = hit ? hit_way : alloc_way;

    always_comb begin
        touch_en  = 1'b0;
        touch_set = idx;
        touch_way = wr_way;
        if (state == S_EVICT) begin
            touch_en  = seq_last;
            touch_set = h_idx;
            touch_way = h_way;
        end else if (accept && (hit || direct_wr)) begin
            touch_en = 1'b1;
        end
    end

    sdir_plru u_plru (
        .clk(clk), .rst(rst), .rd_set(idx), .victim(plru_way),
        .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way)
    );

    sdir_inv_seq u_seq (
        .clk(clk), .rst(rst), .load(need_evict), .load_vec(victim.sharers),
        .inv_valid(inv_valid), .inv_node(inv_node), .last(seq_last)
    );

    assign inv_addr = {h_vtag, h_idx};

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) mem[s][w] <= '0;
            h_idx <= '0; h_tag <= '0; h_vtag <= '0; h_way <= '0;
            h_sh  <= '0; h_dirty <= 1'b0;
        end else begin
            if (need_evict) begin
                state   <= S_EVICT;
                h_idx   <= idx;
                h_tag   <= tag;
                h_vtag  <= victim.tag;
                h_way   <= alloc_way;
                h_sh    <= req_sharers;
                h_dirty <= req_dirty;
            end else if (state == S_EVICT && seq_last) begin
                state <= S_IDLE;
                mem[h_idx][h_way] <= '{valid: 1'b1, tag: h_tag, sharers: h_sh, dirty: h_dirty};
            end
            if (direct_wr)
                mem[idx][wr_way] <= '{valid: nonempty, tag: tag, sharers: req_sharers, dirty: req_dirty};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_sharers <= '0; rsp_dirty <= 1'b0;
        end else begin
            rsp_valid   <= accept && !is_upd;
            rsp_hit     <= hit;
            rsp_sharers <= hit ? set_ent[hit_way].sharers : '0;
            rsp_dirty   <= hit && set_ent[hit_way].dirty;
        end
    end

    // R9: no request is taken while invalidations are going out
    a_r9_stall_on_inv: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> !req_ready);
    // R2: a response only follows an accepted lookup
    a_r2_rsp_follows_lookup: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready && req_op == OP_LOOKUP));
    // R1: a miss reports empty state
    a_r1_miss_empty: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |-> (rsp_sharers == '0) && !rsp_dirty);
    // R10: a dirty-only victim never starts the invalidation stream
    a_r10_no_empty_stream: assert property (@(posedge clk) disable iff (rst)
        $rose(inv_valid) |-> $past(req_valid && req_op == OP_UPDATE));
endmodule

// File: tb/sim_sdir_cache.sv
`timescale 1ns/100ps
module sim_sdir_cache;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_op = 1'b0, req_dirty = 1'b0;
    logic [9:0] req_addr = '0;
    logic [7:0] req_sharers = '0;
    logic req_ready, rsp_valid, rsp_hit, rsp_dirty, inv_valid;
    logic [7:0] rsp_sharers;
    logic [9:0] inv_addr;
    logic [2:0] inv_node;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sdir_cache u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_sharers(req_sharers),
        .req_dirty(req_dirty), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_sharers(rsp_sharers), .rsp_dirty(rsp_dirty), .inv_valid(inv_valid),
        .inv_addr(inv_addr), .inv_node(inv_node)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lookup(input string req, input logic [9:0] a, input bit eh,
                          input logic [7:0] es, input bit ed);
        @(negedge clk);
        req_valid = 1; req_op = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk({req, " rsp_valid"}, rsp_valid, 1);
        chk({req, " hit"}, rsp_hit, eh);
        chk({req, " sharers"}, rsp_sharers, es);
        chk({req, " dirty"}, rsp_dirty, ed);
        @(negedge clk);
        chk({req, " rsp one cycle"}, rsp_valid, 0);
    endtask

    task automatic update(input string req, input logic [9:0] a,
                          input logic [7:0] s, input bit d);
        @(negedge clk);
        req_valid = 1; req_op = 1; req_addr = a; req_sharers = s; req_dirty = d;
        @(negedge clk);
        req_valid = 0;
        chk({req, " no stall"}, req_ready, 1);
        chk({req, " no inval"}, inv_valid, 0);
    endtask

    task automatic evict(input string req, input logic [9:0] a, input logic [7:0] s,
                         input bit d, input logic [9:0] vaddr, input logic [7:0] vsh);
        @(negedge clk);
        req_valid = 1; req_op = 1; req_addr = a; req_sharers = s; req_dirty = d;
        @(negedge clk);
        req_valid = 0;
        for (int n = 0; n < 8; n++) begin
            if (vsh[n]) begin
                chk({req, " inv_valid"}, inv_valid, 1);
                chk({req, " inv_node"}, inv_node, n);
                chk({req, " inv_addr"}, inv_addr, vaddr);
                chk({req, " stalled"}, req_ready, 0);
                @(negedge clk);
            end
        end
        chk({req, " stream ended"}, inv_valid, 0);
        chk({req, " ready again"}, req_ready, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 ready", req_ready, 1);
        chk("R1 inv_valid", inv_valid, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        lookup("R1 empty lookup", 10'h005, 0, 8'h00, 0);
    endtask

    task automatic t_basic();
        update("R4 alloc A1", 10'h010, 8'h03, 0);
        lookup("R2 A1", 10'h010, 1, 8'h03, 0);
        update("R4 alloc A2", 10'h020, 8'h80, 1);
        lookup("R2 A2 dirty", 10'h020, 1, 8'h80, 1);
        update("R3 rewrite A1", 10'h010, 8'h0F, 0);
        lookup("R3 A1 new", 10'h010, 1, 8'h0F, 0);
        lookup("R11 other set", 10'h011, 0, 8'h00, 0);
        update("R6 empty miss", 10'h055, 8'h00, 0);
        lookup("R6 still miss", 10'h055, 0, 8'h00, 0);
    endtask

    task automatic t_evict();
        update("R4 alloc A3", 10'h030, 8'h24, 0);
        update("R4 alloc A4", 10'h040, 8'h01, 0);
        lookup("R7 touch A1", 10'h010, 1, 8'h0F, 0);
        // tree points at way 2 (A3)
        evict("R8 evict A3", 10'h050, 8'h40, 0, 10'h030, 8'h24);
        // tree now points at way 1 (A2)
        evict("R7 evict A2", 10'h060, 8'h01, 0, 10'h020, 8'h80);
        lookup("R9 A3 gone", 10'h030, 0, 8'h00, 0);
        lookup("R9 A2 gone", 10'h020, 0, 8'h00, 0);
        lookup("R9 A5 installed", 10'h050, 1, 8'h40, 0);
        lookup("R9 A6 installed", 10'h060, 1, 8'h01, 0);
    endtask

    task automatic t_free();
        update("R5 free A4", 10'h040, 8'h00, 0);
        lookup("R5 A4 miss", 10'h040, 0, 8'h00, 0);
        update("R5 reuse freed way", 10'h070, 8'h02, 0);
        lookup("R5 A7 hit", 10'h070, 1, 8'h02, 0);
        lookup("R5 A1 kept", 10'h010, 1, 8'h0F, 0);
    endtask

    task automatic t_dirty_victim();
        update("R11 set1 w0", 10'h011, 8'h00, 1);
        update("R11 set1 w1", 10'h021, 8'h10, 0);
        update("R11 set1 w2", 10'h031, 8'h10, 0);
        update("R11 set1 w3", 10'h041, 8'h10, 0);
        update("R10 dirty-only victim", 10'h051, 8'h08, 0);
        lookup("R10 victim gone", 10'h011, 0, 8'h00, 0);
        lookup("R10 new entry", 10'h051, 1, 8'h08, 0);
        lookup("R11 set0 untouched", 10'h050, 1, 8'h40, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_evict();
        t_free();
        t_dirty_victim();
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule